// File: doc/BRIEF.md
# Ten-Input Cascaded Priority Encoder

This block turns ten active-low request lines into the 4-bit binary index of the highest-numbered line that is requesting. It is purely combinational. An active-low enable gates the whole encoder. Two active-low status flags come out beside the code. One says that some request was seen. The other grants permission to a further encoder stage wired below this one.

Internally the encoder is not one flat priority statement. It is two identical 8-input priority cells. Each cell has its own enable in, enable out and "any request" flag. The cell holding lines 9 and 8 sits on top, and its six spare inputs are tied idle. Its enable out feeds the enable in of the cell holding lines 7 to 0. A thin glue stage merges the two codes and flags into the final outputs.

Top module: `pe10_cascade`

## Requirements
- R1: Request inputs are active-low: a line counts as requesting only while its bit of `reqN` is 0.
- R2: While `enInN` is 1, `code` is 0, `grpN` is 1 and `enOutN` is 1, whatever the request lines hold.
- R3: While `enInN` is 0 and at least one line is requesting, `code` equals the largest index i (0 to 9) with `reqN[i]` = 0.
- R4: While `enInN` is 0 and no line is requesting, `code` is 0, `grpN` is 1 and `enOutN` is 0.
- R5: While `enInN` is 0 and at least one line is requesting, `grpN` is 0 and `enOutN` is 1.
- R6: When several lines request together, the higher index wins: lines 5 and 2 together give code 5.
- R7: Codes at the boundaries are exact. All ten lines requesting gives 9. Line 8 alone gives 8, and line 7 alone gives 7, where the two cells meet. Line 0 alone gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqN | input | 10 | Request lines, active-low, index 9 has top priority |
| enInN | input | 1 | Encoder enable, active-low |
| code | output | 4 | Index of the highest requesting line, active-high |
| grpN | output | 1 | Low when enabled and some line requests |
| enOutN | output | 1 | Low when enabled and no line requests; enables a lower stage |

## Verification
The checker assumes that `reqN` and `enInN` are settled two-state values whenever outputs are observed. This matters because the block has no clock, so a glitch between evaluations has no meaning here. The stimulus meets this assumption by changing inputs only on one clock edge and reading outputs on the opposite edge. Every one of the 2048 combinations of enable and request lines is applied once, so no input pattern falls outside what the checker's properties cover.

// File: rtl/pe10_pkg.sv
package pe10_pkg;
  localparam int CELL_IN = 8;
  localparam int CELL_CODE_W = $clog2(CELL_IN);
  localparam int NUM_REQ = 10;
  localparam int HI_USED = NUM_REQ - CELL_IN;
  localparam int CODE_W = CELL_CODE_W + 1;

  // strobes a cell hands to the glue stage (all active-low)
  typedef struct packed {
    logic grpN;
    logic enOutN;
  } cellFlags_t;
endpackage

// File: rtl/pe8_cell.sv
module pe8_cell
  import pe10_pkg::*;
#(
  parameter int WIDTH = CELL_IN,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] reqN,
  input  logic             enInN,
  output logic [CW-1:0]    codeOut,
  output cellFlags_t       flags
);
  logic anyReq;

  always_comb begin
    codeOut = '0;
    anyReq = 1'b0;
    if (!enInN) begin
      // ascending scan: a later (higher) hit overrides an earlier one
      for (int i = 0; i < WIDTH; i++) begin
        if (!reqN[i]) begin
          codeOut = CW'(i);
          anyReq = 1'b1;
        end
      end
    end
  end

  always_comb begin
    flags.grpN = !(anyReq && !enInN);
    flags.enOutN = !(!anyReq && !enInN);
  end
endmodule

// File: rtl/pe10_glue.sv
module pe10_glue
  import pe10_pkg::*;
(
  input  logic [CELL_CODE_W-1:0] hiCode,
  input  logic [CELL_CODE_W-1:0] loCode,
  input  cellFlags_t             hiFlags,
  input  cellFlags_t             loFlags,
  output logic [CODE_W-1:0]      code,
  output logic                   grpN,
  output logic                   enOutN
);
  always_comb begin
    code = {!hiFlags.grpN, hiCode | loCode};
    grpN = hiFlags.grpN & loFlags.grpN;
    enOutN = loFlags.enOutN;
  end
endmodule

// File: rtl/pe10_cascade.sv
module pe10_cascade
  import pe10_pkg::*;
(
  input  logic [9:0] reqN,
  input  logic       enInN,
  output logic [3:0] code,
  output logic       grpN,
  output logic       enOutN
);
  localparam int SPARE = CELL_IN - HI_USED;

  logic [CELL_IN-1:0]     hiReqN;
  logic [CELL_CODE_W-1:0] hiCode;
  logic [CELL_CODE_W-1:0] loCode;
  cellFlags_t             hiFlags;
  cellFlags_t             loFlags;

  assign hiReqN = {{SPARE{1'b1}}, reqN[NUM_REQ-1:CELL_IN]};

  pe8_cell #(.WIDTH(CELL_IN)) i_hiCell (
    .reqN(hiReqN), .enInN(enInN), .codeOut(hiCode), .flags(hiFlags)
  );

  pe8_cell #(.WIDTH(CELL_IN)) i_loCell (
    .reqN(reqN[CELL_IN-1:0]), .enInN(hiFlags.enOutN),
    .codeOut(loCode), .flags(loFlags)
  );

  pe10_glue i_glue (
    .hiCode(hiCode), .loCode(loCode), .hiFlags(hiFlags), .loFlags(loFlags),
    .code(code), .grpN(grpN), .enOutN(enOutN)
  );
endmodule

// File: rtl/pe10_cascade_chk.sv
module pe10_cascade_chk (
  input logic [9:0] reqN,
  input logic       enInN,
  input logic [3:0] code,
  input logic       grpN,
  input logic       enOutN
);
  logic higherIdle;

  always_comb begin
    higherIdle = 1'b1;
    for (int i = 0; i < 10; i++)
      if (i > int'(code) && !reqN[i]) higherIdle = 1'b0;
  end

  always_comb begin
    // R2
    a_r2_disabled_quiet: assert (!enInN || (code == 4'd0 && grpN && enOutN));
    // R4 and R5: flags never both asserted while enabled
    a_r5_flags_exclusive: assert (enInN || (grpN != enOutN));
    // R4
    a_r4_idle_code_zero: assert (enInN || !grpN || code == 4'd0);
    // R5
    a_r5_grp_tracks_any: assert (enInN || (grpN == (&reqN)));
    // R3
    a_r3_code_in_range: assert (grpN || code <= 4'd9);
    // R1 / R3: the coded line is itself requesting
    a_r1_coded_line_low: assert (grpN || code > 4'd9 || !reqN[code]);
    // R6
    a_r6_no_higher_request: assert (grpN || higherIdle);
  end
endmodule

bind pe10_cascade pe10_cascade_chk i_chk (
  .reqN(reqN), .enInN(enInN), .code(code), .grpN(grpN), .enOutN(enOutN)
);

// File: tb/test_pe10_cascade.sv
module test_pe10_cascade;
  logic       clk = 1'b0;
  logic [9:0] reqN = '1;
  logic       enInN = 1'b1;
  logic [3:0] code;
  logic       grpN;
  logic       enOutN;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pe10_cascade i_pe10_cascade (
    .reqN(reqN), .enInN(enInN), .code(code), .grpN(grpN), .enOutN(enOutN)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: reqN=%b enInN=%b actual=%0d expected=%0d",
               tag, reqN, enInN, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic [9:0] r);
    @(posedge clk);
    enInN = en;
    reqN = r;
    @(negedge clk);
  endtask

  initial begin
    int hiIdx;
    apply(1'b1, '1);
    check("R2 reset code", int'(code), 0);
    check("R2 reset grpN", int'(grpN), 1);
    check("R2 reset enOutN", int'(enOutN), 1);

    for (int p = 0; p < 2048; p++) begin
      apply(p[10], p[9:0]);
      hiIdx = -1;
      for (int i = 9; i >= 0; i--)
        if (hiIdx < 0 && !p[i]) hiIdx = i;
      if (p[10]) begin
        check("R2 code", int'(code), 0);
        check("R2 grpN", int'(grpN), 1);
        check("R2 enOutN", int'(enOutN), 1);
      end else if (hiIdx < 0) begin
        check("R4 code", int'(code), 0);
        check("R4 grpN", int'(grpN), 1);
        check("R4 enOutN", int'(enOutN), 0);
      end else begin
        check("R3 R1 code", int'(code), hiIdx);
        check("R5 grpN", int'(grpN), 0);
        check("R5 enOutN", int'(enOutN), 1);
      end
    end

    apply(1'b0, 10'b11_1101_1011);
    check("R6 lines 5 and 2", int'(code), 5);
    apply(1'b0, 10'b00_0000_0000);
    check("R7 all lines", int'(code), 9);
    apply(1'b0, 10'b10_1111_1111);
    check("R7 line 8 alone", int'(code), 8);
    apply(1'b0, 10'b11_0111_1111);
    check("R7 line 7 alone", int'(code), 7);
    apply(1'b0, 10'b11_1111_1110);
    check("R7 line 0 alone", int'(code), 0);
    apply(1'b0, 10'b11_1111_1111);
    check("R1 all high idle", int'(grpN), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule